// File: doc/BRIEF.md
# Serial Non-Decimal Nibble Flagger

This block takes a serial bit stream, one bit per accepted clock, and cuts it into consecutive four-bit groups. Each group arrives least significant bit first. When the fourth bit of a group has been taken, the block decides whether the group encodes a decimal digit (0 to 9). If the value is 10 to 15, it raises a single-cycle flag.

The classifier is a decision tree of states. The root state takes bit 0. Two states take bit 1, four take bit 2 and eight leaf states take bit 3. The leaf states are numbered above the seven inner states. Any leaf reached along a path where bits 2 and 1 are both zero can never flag, whatever bit 3 is. A bit-enable input lets the source insert idle cycles without losing group alignment. Reset fixes the group boundary: the first accepted bit after reset is bit 0 of a group.

Top module: `nbcd_serial_detect`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, flag_out is 0. The first bit accepted after reset is bit 0 of a new group, including when reset arrives in the middle of a group.
- R2: A bit is accepted on a rising clock edge where bit_en is 1. Accepted bits are taken in group order: bit 0, bit 1, bit 2, then bit 3. After bit 3 the next accepted bit is bit 0 of the next group.
- R3: When bit 3 of a group is accepted at an edge and the group value is 10 to 15, that is bit3 AND (bit2 OR bit1), flag_out is 1 during the following clock cycle.
- R4: When bit 3 is accepted and the group value is 0 to 9, flag_out stays 0 in the following cycle.
- R5: flag_out is 0 in every cycle that does not directly follow the acceptance of a bit 3. It is never high in two consecutive cycles.
- R6: An edge with bit_en at 0 accepts no bit. The tree position is kept, so idle cycles inside a group do not change its value or its boundary, and flag_out is 0 in the cycle after such an edge.
- R7: With bit_en held at 1, one bit is taken at every edge with no stall. A group therefore completes every fourth edge and back-to-back groups are each classified.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data bit, least significant bit of each group first |
| bit_en | input | 1 | 1 = take ser_in at this edge |
| flag_out | output | 1 | Registered one-cycle pulse marking a group valued 10 to 15 |

## Verification
The embedded properties check, on every cycle, the invariants that do not depend on data. A pulse never lasts two cycles. A stalled edge neither moves the tree nor raises the flag. A leaf state always returns to the root on an accepted bit. Every pulse follows an accepted 1 taken in a leaf state. Whether the correct values flag, whether the group boundary is placed correctly after reset and after idle gaps, and whether a mid-group reset realigns the stream can only be shown by the bench. It compares each cycle's flag against a reference that rebuilds the group value from directed nibbles and random streams.

// File: rtl/nbcd_pkg.sv
package nbcd_pkg;
  localparam int GROUP_BITS = 4;
  localparam int TREE_NODES = (1 << GROUP_BITS) - 1;
  localparam int LEAF_BASE  = (1 << (GROUP_BITS - 1)) - 1;
  localparam int LEAF_COUNT = 1 << (GROUP_BITS - 1);
  localparam int ST_W       = $clog2(TREE_NODES);
  localparam int LEAF_W     = GROUP_BITS - 1;

  // heap-ordered decision tree: children of node n are 2n+1 (bit 0) and 2n+2 (bit 1)
  typedef enum logic [ST_W-1:0] {
    ST_ROOT, ST_L1_0, ST_L1_1,
    ST_L2_0, ST_L2_1, ST_L2_2, ST_L2_3,
    ST_L3_0, ST_L3_1, ST_L3_2, ST_L3_3, ST_L3_4, ST_L3_5, ST_L3_6, ST_L3_7
  } tree_st_e;

  function automatic logic is_leaf(tree_st_e s);
    return 32'(s) >= LEAF_BASE;
  endfunction

  function automatic tree_st_e step(tree_st_e s, logic b);
    logic [ST_W:0] child;
    child = {s, 1'b0} + (ST_W+1)'(1) + {{ST_W{1'b0}}, b};
    if (is_leaf(s)) return ST_ROOT;
    return tree_st_e'(child[ST_W-1:0]);
  endfunction
endpackage

// File: rtl/nbcd_tree_fsm.sv
module nbcd_tree_fsm
  import nbcd_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     take,
  input  logic     bit_in,
  output tree_st_e state,
  output logic     at_leaf,
  output logic     leaf_arm
);
  logic [LEAF_COUNT-1:0] arm_vec;
  logic [ST_W-1:0]       leaf_off;

  // leaf offset bits along the path: [LEAF_W-1]=bit0, ..., [0]=bit(GROUP_BITS-2)
  // a leaf arms the flag when bit2 or bit1 of the group was 1
  for (genvar k = 0; k < LEAF_COUNT; k++) begin : g_arm
    assign arm_vec[k] = ((k & 1) != 0) || ((k & 2) != 0);
  end

  assign at_leaf  = is_leaf(state);
  assign leaf_off = state - ST_W'(LEAF_BASE);
  assign leaf_arm = at_leaf && arm_vec[leaf_off[LEAF_W-1:0]];

  always_ff @(posedge clk) begin
    if (rst)       state <= ST_ROOT;
    else if (take) state <= step(state, bit_in);
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(state));
  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (take && at_leaf) |=> (state == ST_ROOT));
endmodule

// File: rtl/nbcd_flag_reg.sv
module nbcd_flag_reg (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic bit_in,
  input  logic at_leaf,
  input  logic leaf_arm,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= take && at_leaf && leaf_arm && bit_in;
  end

  p_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    flag |=> !flag);
  p_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !take |=> !flag);
  p_source_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> ($past(take) && $past(bit_in) && $past(at_leaf)));
endmodule

// File: rtl/nbcd_serial_detect.sv
module nbcd_serial_detect
  import nbcd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ser_in,
  input  logic bit_en,
  output logic flag_out
);
  tree_st_e st;
  logic     leaf_q;
  logic     arm_q;

  nbcd_tree_fsm u_tree (
    .clk      (clk),
    .rst      (rst),
    .take     (bit_en),
    .bit_in   (ser_in),
    .state    (st),
    .at_leaf  (leaf_q),
    .leaf_arm (arm_q)
  );

  nbcd_flag_reg u_flag (
    .clk      (clk),
    .rst      (rst),
    .take     (bit_en),
    .bit_in   (ser_in),
    .at_leaf  (leaf_q),
    .leaf_arm (arm_q),
    .flag     (flag_out)
  );
endmodule

// File: tb/sim_nbcd_serial_detect.sv
module sim_nbcd_serial_detect;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_in = 1'b0;
  logic bit_en = 1'b0;
  logic flag_out;

  int total = 0;
  int bad = 0;
  int cnt = 0;
  logic [3:0] acc = 4'd0;
  bit done = 0;

  always #5 clk = ~clk;

  nbcd_serial_detect u0 (
    .clk(clk), .rst(rst), .ser_in(ser_in), .bit_en(bit_en), .flag_out(flag_out)
  );

  function automatic logic ref_flag(logic [3:0] v);
    return v > 4'd9;
  endfunction

  task automatic check(logic exp, string req);
    total++;
    if (flag_out !== exp) begin
      bad++;
      $display("FAIL %s: flag_out=%b expected=%b (time %0t)", req, flag_out, exp, $time);
    end
  endtask

  // drive one cycle, then check the flag registered at that edge
  task automatic cyc(logic b, logic en, logic r);
    logic exp;
    string req;
    @(negedge clk);
    ser_in = b; bit_en = en; rst = r;
    @(posedge clk);
    #1;
    if (r) begin
      cnt = 0; acc = 4'd0; exp = 1'b0; req = "R1";
    end else if (!en) begin
      exp = 1'b0; req = "R6";
    end else begin
      acc[cnt] = b;
      if (cnt == 3) begin
        exp = ref_flag(acc);
        req = exp ? "R3" : "R4";
        cnt = 0;
      end else begin
        cnt++; exp = 1'b0; req = "R5";
      end
    end
    check(exp, req);
  endtask

  task automatic nibble(logic [3:0] v);
    for (int i = 0; i < 4; i++) cyc(v[i], 1'b1, 1'b0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    // R1: reset state
    cyc(1'b1, 1'b1, 1'b1);
    cyc(1'b1, 1'b1, 1'b1);
    // R1: first cycle after reset
    cyc(1'b0, 1'b0, 1'b0);
    // R3/R4/R7: every value, back to back
    for (int v = 0; v < 16; v++) nibble(4'(v));
    // R4: values whose bits 2 and 1 are zero with bit 3 set (8, 9)
    nibble(4'd8); nibble(4'd9);
    // R3/R5: consecutive flagged groups never merge pulses
    nibble(4'd15); nibble(4'd10); nibble(4'd12);
    // R6: idle gaps inside a group keep its value and boundary
    cyc(1'b0, 1'b1, 1'b0);
    cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b1, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 1'b0);
    cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b1, 1'b1, 1'b0);   // value 10 -> R3
    // R1: reset mid group realigns the boundary
    cyc(1'b1, 1'b1, 1'b0);
    cyc(1'b1, 1'b1, 1'b0);
    cyc(1'b0, 1'b1, 1'b1);
    nibble(4'd11);
    nibble(4'd3);
    // R7: random stream with enable held high
    for (int i = 0; i < 400; i++) cyc(1'($urandom), 1'b1, 1'b0);
    // R6: random stream with random enable
    for (int i = 0; i < 600; i++) cyc(1'($urandom), 1'(($urandom % 3) != 0), 1'b0);
    // R2: rare resets in a random stream
    for (int i = 0; i < 300; i++) cyc(1'($urandom), 1'b1, 1'(($urandom % 50) == 0));
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule